// File: doc/BRIEF.md
# Serial-Clocked Successive-Approximation Converter Core

This block is the digital half of a 10-bit successive-approximation converter. The conversion is paced entirely by an external serial clock. A host lowers the active-low select to freeze the analog sample. It then toggles the serial clock. Each rising clock edge resolves one bit against the comparator and shifts that bit out at once, most significant first. The analog hold switch, capacitive DAC, comparator and reference lie outside the block. The core drives a trial code into the DAC, reads back the single comparator decision, and controls the hold switch and the reference enable.

The block runs on a fast local clock. The select, serial clock and shutdown pins pass through synchronizer chains, and their edges become single-cycle events. A frame has a fixed layout. Two leading zero slots come first, then ten result slots, then two confirmation slots that repeat the comparator verdict on the final code, and then zeros for as long as the host keeps clocking. Raising the select at any point ends the frame. Lowering the active-low shutdown switches the reference off and blocks or aborts conversions.

Top module: `serial_sar_core`

## Requirements
- R1: A synchronized falling edge of `cs_n` while shutdown is inactive starts a frame. On the following cycle `hold`=1, `sdo_oe`=1, `sdo`=0 and `done`=0, and `result` is cleared to 0.
- R2: The first and second serial rising edges of a frame put 0 on `sdo`. The second edge also loads the trial code 10'h200 (only bit 9 set) onto `dac_code`.
- R3: Rising edges 3 to 12 resolve bits 9 down to 0 in that order. The bit under trial is kept when `cmp` is 1 and cleared when it is 0, and the decided bit is placed on `sdo`. The next lower bit is then set as the new trial.
- R4: Rising edges 13 and 14 are confirmation slots. Each places the current `cmp` value, taken against the final code, on `sdo` and leaves `dac_code` unchanged.
- R5: Every rising edge after the 14th places 0 on `sdo` and changes neither `dac_code` nor `result`.
- R6: `sdo` changes only in the cycle after a synchronized serial rising edge, or when a frame starts or ends. It never changes on a serial falling edge.
- R7: A synchronized rising edge of `cs_n` makes `hold`=0 and `sdo_oe`=0 and returns `dac_code` to 0. If the frame ends before bit 0 is resolved, `done` stays 0 and `result` stays 0.
- R8: While `shdn_n` is low, `ref_en` is 0, a falling edge of `cs_n` starts nothing, and a frame already running is aborted as in R7. With `shdn_n` high, `ref_en` is 1.
- R9: `done` rises once bit 0 has been resolved, and `result` then equals the resolved code. Both hold through the select going high until the next frame starts.
- R10: An asynchronous low on `rst_n` forces `hold`=0, `sdo_oe`=0, `sdo`=0, `done`=0, `dac_code`=0 and `result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; falling edge starts a frame, rising edge ends it |
| sclk | input | 1 | Serial clock; each rising edge advances the frame |
| shdn_n | input | 1 | Active-low shutdown |
| cmp | input | 1 | Comparator verdict: 1 when the input is at or above the trial code |
| dac_code | output | 10 | Trial code driven into the capacitive DAC |
| hold | output | 1 | 1 holds the sample, 0 tracks the input |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Serial data drive enable; 0 means high impedance |
| ref_en | output | 1 | Reference enable |
| done | output | 1 | Conversion complete flag |
| result | output | 10 | Last completed conversion code |

## Verification
The hardest state to reach from the ports is an interrupted frame. A frame can be cut short by the select partway through the result slots, by shutdown while bits are still pending, or by reset in the middle of a conversion. In each case `done` and `result` must show no partial code. The bench drives the comparator from a behavioural model that compares a chosen input level with `dac_code`. It stops the serial clock after a chosen number of edges and then raises the select, lowers shutdown, or asserts reset. Frames that overrun to 18 and 20 edges exercise the saturated tail.

// File: rtl/sar_core_pkg.sv
`timescale 1ns/1ps
package sar_core_pkg;

  typedef enum logic {
    PH_IDLE    = 1'b0,
    PH_CONVERT = 1'b1
  } phase_e;

  typedef enum logic [2:0] {
    SLOT_NONE,
    SLOT_LEAD,
    SLOT_DATA,
    SLOT_CONFIRM,
    SLOT_PAD
  } slot_e;

  // Classify a 1-based serial edge number within a frame.
  function automatic slot_e slot_of(input int unsigned edge_no,
                                    input int unsigned lead,
                                    input int unsigned res,
                                    input int unsigned confirm);
    if (edge_no == 0)                          return SLOT_NONE;
    else if (edge_no <= lead)                  return SLOT_LEAD;
    else if (edge_no <= lead + res)            return SLOT_DATA;
    else if (edge_no <= lead + res + confirm)  return SLOT_CONFIRM;
    else                                       return SLOT_PAD;
  endfunction

  // Bit position resolved by a data-slot edge (MSB first).
  function automatic int unsigned data_bit_of(input int unsigned edge_no,
                                              input int unsigned lead,
                                              input int unsigned res);
    return lead + res - edge_no;
  endfunction

endpackage

// File: rtl/sig_sync.sv
`timescale 1ns/1ps
module sig_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic q,
  output logic q_d
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_d <= RST_VAL;
    else        q_d <= chain[STAGES-1];
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/sar_register.sv
`timescale 1ns/1ps
module sar_register #(
  parameter int RES   = 10,
  parameter int IDX_W = $clog2(RES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load_msb,
  input  logic             decide,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             cmp,
  output logic [RES-1:0]   code,
  output logic [RES-1:0]   code_next
);

  always_comb begin
    code_next = code;
    if (clear) begin
      code_next = '0;
    end else if (load_msb) begin
      code_next          = '0;
      code_next[RES-1]   = 1'b1;
    end else if (decide) begin
      for (int i = 0; i < RES; i++) begin
        if (i == int'(bit_idx))
          code_next[i] = cmp;
        else if (i == int'(bit_idx) - 1)
          code_next[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code <= '0;
    else        code <= code_next;
  end

endmodule

// File: rtl/frame_ctrl.sv
`timescale 1ns/1ps
module frame_ctrl
  import sar_core_pkg::*;
#(
  parameter int RES       = 10,
  parameter int LEAD      = 2,
  parameter int CONFIRM   = 2,
  parameter int FRAME_LEN = 16,
  parameter int IDX_W     = $clog2(RES),
  parameter int CNT_W     = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             sclk_rise,
  input  logic             cmp,
  output logic             hold,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             done,
  output logic [CNT_W-1:0] edge_cnt,
  output logic             sar_clear,
  output logic             sar_load,
  output logic             sar_decide,
  output logic             last_bit,
  output logic [IDX_W-1:0] bit_idx
);

  phase_e           phase;
  logic [CNT_W-1:0] edge_nxt;
  slot_e            slot;
  logic             step;

  assign step     = (phase == PH_CONVERT) && sclk_rise && !stop_req;
  assign edge_nxt = (edge_cnt == CNT_W'(FRAME_LEN)) ? edge_cnt : edge_cnt + 1'b1;
  assign slot     = slot_of(int'(edge_nxt), LEAD, RES, CONFIRM);
  assign bit_idx  = IDX_W'(data_bit_of(int'(edge_nxt), LEAD, RES));

  assign sar_clear  = start_req || stop_req;
  assign sar_load   = step && (int'(edge_nxt) == LEAD);
  assign sar_decide = step && (slot == SLOT_DATA);
  assign last_bit   = sar_decide && (bit_idx == '0);
  assign hold       = (phase == PH_CONVERT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      edge_cnt <= '0;
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
      done     <= 1'b0;
    end else if (stop_req) begin
      phase    <= PH_IDLE;
      edge_cnt <= '0;
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
    end else if (start_req) begin
      phase    <= PH_CONVERT;
      edge_cnt <= '0;
      sdo      <= 1'b0;
      sdo_oe   <= 1'b1;
      done     <= 1'b0;
    end else if (step) begin
      edge_cnt <= edge_nxt;
      case (slot)
        SLOT_DATA: begin
          sdo <= cmp;
          if (last_bit) done <= 1'b1;
        end
        SLOT_CONFIRM: sdo <= cmp;
        default:      sdo <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/serial_sar_core.sv
`timescale 1ns/1ps
module serial_sar_core #(
  parameter int RES         = 10,
  parameter int LEAD        = 2,
  parameter int CONFIRM     = 2,
  parameter int FRAME_LEN   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           sclk,
  input  logic           shdn_n,
  input  logic           cmp,
  output logic [RES-1:0] dac_code,
  output logic           hold,
  output logic           sdo,
  output logic           sdo_oe,
  output logic           ref_en,
  output logic           done,
  output logic [RES-1:0] result
);

  localparam int IDX_W = $clog2(RES);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);

  logic cs_q, cs_qd, sclk_q, sclk_qd, shdn_q, shdn_qd;
  logic cs_fall_evt, cs_rise_evt, sclk_rise_evt, shdn_ok;
  logic start_evt, stop_evt;
  logic sar_clear, sar_load, sar_decide, last_bit;
  logic [IDX_W-1:0] bit_idx;
  logic [CNT_W-1:0] edge_cnt;
  logic [RES-1:0]   code_next;

  sig_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .din(cs_n), .q(cs_q), .q_d(cs_qd));

  sig_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .din(sclk), .q(sclk_q), .q_d(sclk_qd));

  sig_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_shdn_sync (
    .clk(clk), .rst_n(rst_n), .din(shdn_n), .q(shdn_q), .q_d(shdn_qd));

  assign cs_fall_evt   = cs_qd && !cs_q;
  assign cs_rise_evt   = !cs_qd && cs_q;
  assign sclk_rise_evt = !sclk_qd && sclk_q;
  assign shdn_ok       = shdn_q && shdn_qd;
  assign ref_en        = shdn_ok;

  assign start_evt = cs_fall_evt && shdn_ok && !hold;
  assign stop_evt  = hold && (cs_rise_evt || !shdn_ok);

  frame_ctrl #(
    .RES(RES), .LEAD(LEAD), .CONFIRM(CONFIRM), .FRAME_LEN(FRAME_LEN),
    .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start_req(start_evt), .stop_req(stop_evt), .sclk_rise(sclk_rise_evt),
    .cmp(cmp),
    .hold(hold), .sdo(sdo), .sdo_oe(sdo_oe), .done(done),
    .edge_cnt(edge_cnt),
    .sar_clear(sar_clear), .sar_load(sar_load), .sar_decide(sar_decide),
    .last_bit(last_bit), .bit_idx(bit_idx)
  );

  sar_register #(.RES(RES), .IDX_W(IDX_W)) u_sar (
    .clk(clk), .rst_n(rst_n),
    .clear(sar_clear), .load_msb(sar_load), .decide(sar_decide),
    .bit_idx(bit_idx), .cmp(cmp),
    .code(dac_code), .code_next(code_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          result <= '0;
    else if (start_evt)  result <= '0;
    else if (last_bit)   result <= code_next;
  end

endmodule

// File: rtl/serial_sar_core_chk.sv
`timescale 1ns/1ps
module serial_sar_core_chk #(
  parameter int RES       = 10,
  parameter int LEAD      = 2,
  parameter int CONFIRM   = 2,
  parameter int FRAME_LEN = 16,
  parameter int CNT_W     = $clog2(FRAME_LEN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             sclk_rise_evt,
  input logic             shdn_ok,
  input logic             sar_load,
  input logic             last_bit,
  input logic [CNT_W-1:0] edge_cnt,
  input logic             hold,
  input logic             sdo,
  input logic             sdo_oe,
  input logic             done,
  input logic [RES-1:0]   dac_code,
  input logic [RES-1:0]   result
);

  a_r1_start_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> hold && sdo_oe && !sdo && !done && (result == '0));

  a_r2_msb_trial: assert property (@(posedge clk) disable iff (!rst_n)
    sar_load |=> dac_code == {1'b1, {(RES-1){1'b0}}});

  a_r5_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && int'(edge_cnt) > LEAD + RES + CONFIRM) |-> !sdo);

  a_r6_sdo_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && !$past(sclk_rise_evt)) |-> $stable(sdo));

  a_r7_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !hold && !sdo_oe && (dac_code == '0));

  a_r8_shutdown_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_ok |=> !hold);

  a_r9_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    last_bit |=> done && (result == dac_code));

  a_r9_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!last_bit && !start_evt) |=> $stable(result));

endmodule

bind serial_sar_core serial_sar_core_chk #(
  .RES(RES), .LEAD(LEAD), .CONFIRM(CONFIRM), .FRAME_LEN(FRAME_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
  .sclk_rise_evt(sclk_rise_evt), .shdn_ok(shdn_ok), .sar_load(sar_load),
  .last_bit(last_bit), .edge_cnt(edge_cnt), .hold(hold), .sdo(sdo),
  .sdo_oe(sdo_oe), .done(done), .dac_code(dac_code), .result(result)
);

// File: tb/tb_serial_sar_core.sv
`timescale 1ns/1ps
module tb_serial_sar_core;

  localparam int RES = 10;
  localparam int NVEC = 8;
  localparam logic [RES-1:0] VIN_TAB [NVEC] =
    '{10'h000, 10'h3FF, 10'h200, 10'h1FF, 10'h155, 10'h2AA, 10'h001, 10'h0C3};
  localparam int EDGE_TAB [NVEC] = '{16, 16, 16, 16, 16, 20, 16, 18};

  logic clk = 1'b0;
  logic rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, shdn_n = 1'b1;
  logic [RES-1:0] vin = '0;
  logic cmp;
  logic [RES-1:0] dac_code, result;
  logic hold, sdo, sdo_oe, ref_en, done;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  // Behavioural comparator: input at or above trial code
  assign cmp = (vin >= dac_code);

  serial_sar_core dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .shdn_n(shdn_n),
    .cmp(cmp), .dac_code(dac_code), .hold(hold), .sdo(sdo), .sdo_oe(sdo_oe),
    .ref_en(ref_en), .done(done), .result(result));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  function automatic logic exp_bit(input logic [RES-1:0] v, input int e);
    if (e <= 2)       return 1'b0;
    else if (e <= 12) return v[12 - e];
    else if (e <= 14) return 1'b1;
    else              return 1'b0;
  endfunction

  function automatic string tag_of(input int e);
    if (e <= 2)       return "R2";
    else if (e <= 12) return "R3";
    else if (e <= 14) return "R4";
    else              return "R5";
  endfunction

  task automatic pulse_sclk(output logic after_rise, output logic after_fall);
    @(negedge clk) sclk = 1'b1;
    settle();
    after_rise = sdo;
    @(negedge clk) sclk = 1'b0;
    settle();
    after_fall = sdo;
  endtask

  task automatic begin_frame(input logic [RES-1:0] v);
    vin = v;
    @(negedge clk) cs_n = 1'b0;
    settle();
  endtask

  task automatic end_frame();
    @(negedge clk) cs_n = 1'b1;
    settle();
  endtask

  task automatic run_frame(input logic [RES-1:0] v, input int n_edges);
    logic a, b;
    begin_frame(v);
    check(hold && sdo_oe && !sdo && !done && result == '0, "R1",
          {hold, sdo_oe, sdo, done}, 4'b1100);
    for (int e = 1; e <= n_edges; e++) begin
      pulse_sclk(a, b);
      check(a == exp_bit(v, e), tag_of(e), a, exp_bit(v, e));
      check(b == a, "R6", b, a);
      if (e == 2) check(dac_code == 10'h200, "R2", dac_code, 10'h200);
      if (e == 12) check(done && result == v, "R9", result, v);
      if (e == n_edges) check(dac_code == v && result == v, "R5", dac_code, v);
    end
    end_frame();
    check(!hold && !sdo_oe, "R7", {hold, sdo_oe}, 0);
    check(done && result == v, "R9", result, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic a, b;
    // R10: reset state
    repeat (4) @(negedge clk);
    check(!hold && !sdo_oe && !sdo && !done && dac_code == '0 && result == '0,
          "R10", {hold, sdo_oe, sdo, done}, 0);
    check(!ref_en, "R10", ref_en, 0);
    @(negedge clk) rst_n = 1'b1;
    settle();
    check(ref_en, "R8", ref_en, 1);

    // Table of frames
    for (int i = 0; i < NVEC; i++) run_frame(VIN_TAB[i], EDGE_TAB[i]);

    // R7: abort by select partway through the result bits
    begin_frame(10'h2AA);
    for (int e = 1; e <= 7; e++) pulse_sclk(a, b);
    end_frame();
    check(!hold && !sdo_oe && !done && result == '0 && dac_code == '0, "R7",
          result, 0);

    // R8: shutdown blocks a start
    @(negedge clk) shdn_n = 1'b0;
    settle();
    check(!ref_en, "R8", ref_en, 0);
    begin_frame(10'h155);
    check(!hold && !sdo_oe, "R8", {hold, sdo_oe}, 0);
    pulse_sclk(a, b);
    check(dac_code == '0 && !sdo_oe, "R8", dac_code, 0);
    end_frame();
    @(negedge clk) shdn_n = 1'b1;
    settle();
    check(ref_en, "R8", ref_en, 1);

    // R8: shutdown aborts a running frame
    begin_frame(10'h3C3);
    for (int e = 1; e <= 5; e++) pulse_sclk(a, b);
    @(negedge clk) shdn_n = 1'b0;
    settle();
    check(!hold && !sdo_oe && !done && result == '0, "R8", {hold, sdo_oe, done}, 0);
    end_frame();
    @(negedge clk) shdn_n = 1'b1;
    settle();

    // R9: result survives a fresh frame only until its start
    run_frame(10'h0F0, 16);
    begin_frame(10'h00F);
    check(result == '0 && !done, "R1", result, 0);
    end_frame();

    // R10: asynchronous reset mid-conversion
    begin_frame(10'h2FF);
    for (int e = 1; e <= 6; e++) pulse_sclk(a, b);
    @(negedge clk) rst_n = 1'b0;
    #1;
    check(!hold && !sdo_oe && !sdo && dac_code == '0 && result == '0 && !done,
          "R10", {hold, sdo_oe, sdo}, 0);
    @(negedge clk) begin
      cs_n = 1'b1;
      rst_n = 1'b1;
    end
    settle();

    // Frame after reset still converts
    run_frame(10'h37E, 16);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule